// File: doc/BRIEF.md
# Protected Command Sequence Decoder

This block interprets qualified bus-write cycles sent to a parallel flash device whose contents are guarded by a software unlock scheme. Each accepted write carries an address and a data word. The block tracks how far an unlock sequence has progressed. It decides whether the host has asked for one of the following:

- a program operation;
- an erase operation of the whole chip, a sector or a block;
- entry into or exit from the identification mode;
- entry into or exit from the parameter-query (CFI) mode.

The block presents one registered mode code, together with the target address, data and erase scope of the last request. An operation engine consumes program and erase requests and reports back through a busy input. A read path uses the ID and CFI modes to choose what a read returns. The array, the identification values and the query table lie outside this block.

Command cycles compare only the low data byte and the low address bits. The unlock pair is 0xAA written to 0x555, then 0x55 written to 0x2AA. The third cycle carries the opcode. A program request takes three cycles plus the data cycle. An erase takes six cycles: an erase setup, then a second unlock pair, then the erase kind. A single write of 0x98 to 0x55 is a shortcut into query mode. A cycle that breaks a sequence sends the tracker back to its start and drops the device to read mode. While the engine is busy, a request to leave ID or CFI mode has no effect.

Top module: `cmd_seq_decoder`

## Requirements
- R1: After synchronous reset, mode_o is 0 (read), and op_addr_o, op_data_o and erase_scope_o are all 0.
- R2: The writes 0xAA@0x555, 0x55@0x2AA and 0xA0@0x555, followed by any write, produce mode_o = 3 (program) in the cycle after that fourth write. op_addr_o and op_data_o carry the fourth write's address and data, and erase_scope_o is 0.
- R3: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555 and 0x55@0x2AA, followed by a sixth write, produce mode_o = 4 (erase). The sixth write selects the scope: 0x10@0x555 gives erase_scope_o = 1 (chip), 0x30 at any address gives 2 (sector), and 0x50 at any address gives 3 (block). op_addr_o takes the sixth write's address.
- R4: A write that does not match the next expected cycle returns the tracker to its start. If the engine is not busy, it also sets mode_o to 0, including from ID or CFI mode. Cycles that follow a broken sequence never complete a request.
- R5: The unlock pair followed by 0x90@0x555 sets mode_o = 1 (ID).
- R6: The unlock pair followed by 0x98@0x555 sets mode_o = 2 (CFI).
- R7: A single write of 0x98 to address 0x55, made while no sequence is in progress, sets mode_o = 2 (CFI).
- R8: ID and CFI modes hold over cycles with no write. The unlock pair followed by 0xF0@0x555 returns mode_o to 0.
- R9: While busy_i is 1, neither the exit command nor a mismatched write moves mode_o from ID or CFI to read.
- R10: Only bits 7:0 of the data and bits 10:0 of the address are compared during command cycles. Upper bits have no effect on decoding.
- R11: Program and erase modes last exactly one cycle and occur only in the cycle after a write. mode_o then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | A qualified bus write is present this cycle |
| wr_addr_i | input | ADDR_W (21) | Write address |
| wr_data_i | input | DATA_W (16) | Write data |
| busy_i | input | 1 | Program or erase in progress in the operation engine |
| mode_o | output | 3 | 0 read, 1 ID, 2 CFI, 3 program request, 4 erase request |
| op_addr_o | output | ADDR_W (21) | Address of the last program or erase request |
| op_data_o | output | DATA_W (16) | Data of the last program request |
| erase_scope_o | output | 2 | 0 none/program, 1 chip, 2 sector, 3 block |

## Verification
On every cycle, the assertions check the following:

- a request mode lasts one cycle and appears only after a write;
- an erase always carries a non-zero scope and a program carries none;
- the tracker holds when no write arrives;
- busy blocks any fall from ID or CFI to read;
- the one-write query shortcut always lands in CFI mode.

Some behaviours can only be shown by the bench scenarios. These are the following:

- the exact opcode and address combinations that complete each sequence;
- the captured address and data values;
- recovery after a broken sequence;
- insensitivity to the upper data and address bits.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

  typedef enum logic [2:0] {
    MODE_READ  = 3'd0,
    MODE_ID    = 3'd1,
    MODE_CFI   = 3'd2,
    MODE_PROG  = 3'd3,
    MODE_ERASE = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PDATA,
    ST_ESETUP,
    ST_EUNL1,
    ST_EUNL2
  } seq_e;

  typedef enum logic [3:0] {
    EV_NONE,
    EV_STEP,
    EV_ABORT,
    EV_PROG,
    EV_ERASE_CHIP,
    EV_ERASE_SECT,
    EV_ERASE_BLK,
    EV_ID,
    EV_CFI,
    EV_EXIT
  } event_e;

  typedef struct packed {
    logic unl1;
    logic unl2;
    logic op_prog;
    logic op_erase;
    logic op_id;
    logic op_cfi;
    logic op_exit;
    logic cfi_short;
    logic era_chip;
    logic era_sect;
    logic era_blk;
  } cycle_cls_t;

  localparam logic [1:0] SCOPE_NONE = 2'd0;
  localparam logic [1:0] SCOPE_CHIP = 2'd1;
  localparam logic [1:0] SCOPE_SECT = 2'd2;
  localparam logic [1:0] SCOPE_BLK  = 2'd3;

  localparam logic [7:0] BYTE_UNL1  = 8'hAA;
  localparam logic [7:0] BYTE_UNL2  = 8'h55;
  localparam logic [7:0] BYTE_PROG  = 8'hA0;
  localparam logic [7:0] BYTE_ESET  = 8'h80;
  localparam logic [7:0] BYTE_ID    = 8'h90;
  localparam logic [7:0] BYTE_CFI   = 8'h98;
  localparam logic [7:0] BYTE_EXIT  = 8'hF0;
  localparam logic [7:0] BYTE_CHIP  = 8'h10;
  localparam logic [7:0] BYTE_SECT  = 8'h30;
  localparam logic [7:0] BYTE_BLK   = 8'h50;

endpackage

// File: rtl/cmd_match.sv
module cmd_match
  import cmdseq_pkg::*;
#(
  parameter int CMD_ADDR_BITS = 11
) (
  input  logic [CMD_ADDR_BITS-1:0] key_addr_i,
  input  logic [7:0]               key_byte_i,
  output cycle_cls_t               cls_o
);

  localparam logic [CMD_ADDR_BITS-1:0] KEY_A = CMD_ADDR_BITS'(32'h555);
  localparam logic [CMD_ADDR_BITS-1:0] KEY_B = CMD_ADDR_BITS'(32'h2AA);
  localparam logic [CMD_ADDR_BITS-1:0] KEY_Q = CMD_ADDR_BITS'(32'h055);

  logic at_a, at_b, at_q;

  assign at_a = (key_addr_i == KEY_A);
  assign at_b = (key_addr_i == KEY_B);
  assign at_q = (key_addr_i == KEY_Q);

  always_comb begin
    cls_o           = '0;
    cls_o.unl1      = at_a && (key_byte_i == BYTE_UNL1);
    cls_o.unl2      = at_b && (key_byte_i == BYTE_UNL2);
    cls_o.op_prog   = at_a && (key_byte_i == BYTE_PROG);
    cls_o.op_erase  = at_a && (key_byte_i == BYTE_ESET);
    cls_o.op_id     = at_a && (key_byte_i == BYTE_ID);
    cls_o.op_cfi    = at_a && (key_byte_i == BYTE_CFI);
    cls_o.op_exit   = at_a && (key_byte_i == BYTE_EXIT);
    cls_o.cfi_short = at_q && (key_byte_i == BYTE_CFI);
    cls_o.era_chip  = at_a && (key_byte_i == BYTE_CHIP);
    cls_o.era_sect  = (key_byte_i == BYTE_SECT);
    cls_o.era_blk   = (key_byte_i == BYTE_BLK);
  end

endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
  import cmdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_valid_i,
  input  cycle_cls_t cls_i,
  output event_e     ev_o,
  output seq_e       st_o
);

  seq_e st_q, st_nxt;
  event_e ev;

  always_comb begin
    st_nxt = st_q;
    ev     = EV_NONE;
    if (wr_valid_i) begin
      st_nxt = ST_IDLE;
      ev     = EV_ABORT;
      unique case (st_q)
        ST_IDLE: begin
          if (cls_i.unl1) begin
            st_nxt = ST_UNL1;
            ev     = EV_STEP;
          end else if (cls_i.cfi_short) begin
            ev = EV_CFI;
          end
        end
        ST_UNL1: begin
          if (cls_i.unl2) begin
            st_nxt = ST_UNL2;
            ev     = EV_STEP;
          end
        end
        ST_UNL2: begin
          if (cls_i.op_prog) begin
            st_nxt = ST_PDATA;
            ev     = EV_STEP;
          end else if (cls_i.op_erase) begin
            st_nxt = ST_ESETUP;
            ev     = EV_STEP;
          end else if (cls_i.op_id) begin
            ev = EV_ID;
          end else if (cls_i.op_cfi) begin
            ev = EV_CFI;
          end else if (cls_i.op_exit) begin
            ev = EV_EXIT;
          end
        end
        ST_PDATA: ev = EV_PROG;
        ST_ESETUP: begin
          if (cls_i.unl1) begin
            st_nxt = ST_EUNL1;
            ev     = EV_STEP;
          end
        end
        ST_EUNL1: begin
          if (cls_i.unl2) begin
            st_nxt = ST_EUNL2;
            ev     = EV_STEP;
          end
        end
        ST_EUNL2: begin
          if (cls_i.era_chip)      ev = EV_ERASE_CHIP;
          else if (cls_i.era_sect) ev = EV_ERASE_SECT;
          else if (cls_i.era_blk)  ev = EV_ERASE_BLK;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_nxt;
  end

  assign ev_o = ev;
  assign st_o = st_q;

  // R4: the tracker only moves on a write cycle
  p_hold_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_valid_i |=> $stable(st_q));

endmodule

// File: rtl/mode_reg.sv
module mode_reg
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid_i,
  input  event_e            ev_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output mode_e             mode_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [1:0]        scope_o
);

  mode_e             mode_q, mode_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        scope_q;

  always_comb begin
    mode_nxt = ((mode_q == MODE_PROG) || (mode_q == MODE_ERASE)) ? MODE_READ : mode_q;
    unique case (ev_i)
      EV_PROG:                                  mode_nxt = MODE_PROG;
      EV_ERASE_CHIP, EV_ERASE_SECT, EV_ERASE_BLK: mode_nxt = MODE_ERASE;
      EV_ID:                                    mode_nxt = MODE_ID;
      EV_CFI:                                   mode_nxt = MODE_CFI;
      EV_EXIT, EV_ABORT: if (!busy_i)           mode_nxt = MODE_READ;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_READ;
      addr_q  <= '0;
      data_q  <= '0;
      scope_q <= SCOPE_NONE;
    end else begin
      mode_q <= mode_nxt;
      case (ev_i)
        EV_PROG: begin
          addr_q  <= wr_addr_i;
          data_q  <= wr_data_i;
          scope_q <= SCOPE_NONE;
        end
        EV_ERASE_CHIP: begin
          addr_q  <= wr_addr_i;
          scope_q <= SCOPE_CHIP;
        end
        EV_ERASE_SECT: begin
          addr_q  <= wr_addr_i;
          scope_q <= SCOPE_SECT;
        end
        EV_ERASE_BLK: begin
          addr_q  <= wr_addr_i;
          scope_q <= SCOPE_BLK;
        end
        default: ;
      endcase
    end
  end

  assign mode_o    = mode_q;
  assign op_addr_o = addr_q;
  assign op_data_o = data_q;
  assign scope_o   = scope_q;

  // R11: request modes last a single cycle
  p_req_one_cycle_r11: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == MODE_PROG) || (mode_q == MODE_ERASE)) |=>
      !((mode_q == MODE_PROG) || (mode_q == MODE_ERASE)));

  // R11: a request only follows a write
  p_req_after_write_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_valid_i |=> !((mode_q == MODE_PROG) || (mode_q == MODE_ERASE)));

  // R3: an erase request always names a scope
  p_erase_scope_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_ERASE) |-> (scope_q != SCOPE_NONE));

  // R2: a program request carries no erase scope
  p_prog_scope_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PROG) |-> (scope_q == SCOPE_NONE));

  // R9: busy blocks a fall from ID or CFI to read
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_i && ((mode_q == MODE_ID) || (mode_q == MODE_CFI))) |=> (mode_q != MODE_READ));

endmodule

// File: rtl/cmd_seq_decoder.sv
module cmd_seq_decoder
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W        = 21,
  parameter int DATA_W        = 16,
  parameter int CMD_ADDR_BITS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  output logic [2:0]        mode_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [1:0]        erase_scope_o
);

  localparam logic [CMD_ADDR_BITS-1:0] SHORT_ADDR = CMD_ADDR_BITS'(32'h055);

  cycle_cls_t cls;
  event_e     ev;
  seq_e       seq_st;
  mode_e      mode;

  cmd_match #(.CMD_ADDR_BITS(CMD_ADDR_BITS)) match_i (
    .key_addr_i (wr_addr_i[CMD_ADDR_BITS-1:0]),
    .key_byte_i (wr_data_i[7:0]),
    .cls_o      (cls)
  );

  cmd_fsm fsm_i (
    .clk        (clk),
    .rst        (rst),
    .wr_valid_i (wr_valid_i),
    .cls_i      (cls),
    .ev_o       (ev),
    .st_o       (seq_st)
  );

  mode_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mode_i (
    .clk        (clk),
    .rst        (rst),
    .wr_valid_i (wr_valid_i),
    .ev_i       (ev),
    .busy_i     (busy_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .mode_o     (mode),
    .op_addr_o  (op_addr_o),
    .op_data_o  (op_data_o),
    .scope_o    (erase_scope_o)
  );

  assign mode_o = mode;

  // R7: the one-write query shortcut from an idle tracker lands in CFI mode
  p_cfi_short_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_i && (seq_st == ST_IDLE) && (wr_data_i[7:0] == 8'h98) &&
     (wr_addr_i[CMD_ADDR_BITS-1:0] == SHORT_ADDR)) |=> (mode_o == 3'd2));

endmodule

// File: tb/cmd_seq_decoder_tb.sv
module cmd_seq_decoder_tb_top;

  localparam int ADDR_W = 21;
  localparam int DATA_W = 16;
  localparam int WD_CYCLES = 20000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_valid = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              busy = 1'b0;
  logic [2:0]        mode;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic [1:0]        scope;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  cmd_seq_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .wr_valid_i    (wr_valid),
    .wr_addr_i     (wr_addr),
    .wr_data_i     (wr_data),
    .busy_i        (busy),
    .mode_o        (mode),
    .op_addr_o     (op_addr),
    .op_data_o     (op_data),
    .erase_scope_o (scope)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // one write cycle; returns at the negedge after the sampling edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock_pair();
    wr(21'h555, 16'h00AA);
    wr(21'h2AA, 16'h0055);
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(mode), 32'd0);
    chk("R1 addr", 32'(op_addr), 32'd0);
    chk("R1 data", 32'(op_data), 32'd0);
    chk("R1 scope", 32'(scope), 32'd0);
  endtask

  task automatic t_program();
    unlock_pair();
    wr(21'h555, 16'h00A0);
    chk("R2 no request before data cycle", 32'(mode), 32'd0);
    wr(21'h12345, 16'hBEEF);
    chk("R2 mode", 32'(mode), 32'd3);
    chk("R2 addr", 32'(op_addr), 32'h12345);
    chk("R2 data", 32'(op_data), 32'hBEEF);
    chk("R2 scope", 32'(scope), 32'd0);
    @(negedge clk);
    chk("R11 program lasts one cycle", 32'(mode), 32'd0);
  endtask

  task automatic t_erase(input logic [ADDR_W-1:0] a, input logic [7:0] kind,
                         input logic [1:0] exp_scope);
    unlock_pair();
    wr(21'h555, 16'h0080);
    unlock_pair();
    chk("R3 no request before sixth cycle", 32'(mode), 32'd0);
    wr(a, {8'h00, kind});
    chk("R3 mode", 32'(mode), 32'd4);
    chk("R3 scope", 32'(scope), 32'(exp_scope));
    chk("R3 addr", 32'(op_addr), 32'(a));
    @(negedge clk);
    chk("R11 erase lasts one cycle", 32'(mode), 32'd0);
  endtask

  task automatic t_abort();
    wr(21'h555, 16'h00AA);
    wr(21'h2AA, 16'h0012);
    wr(21'h555, 16'h00A0);
    wr(21'h00100, 16'h1234);
    chk("R4 broken sequence gives no request", 32'(mode), 32'd0);
    t_program();
    unlock_pair();
    wr(21'h555, 16'h0080);
    wr(21'h555, 16'h00AA);
    wr(21'h555, 16'h0055);
    wr(21'h555, 16'h0010);
    chk("R4 broken erase gives no request", 32'(mode), 32'd0);
    unlock_pair();
    wr(21'h555, 16'h0090);
    chk("R5 ID entry", 32'(mode), 32'd1);
    wr(21'h00300, 16'h0000);
    chk("R4 stray write leaves ID", 32'(mode), 32'd0);
  endtask

  task automatic t_id_cfi();
    unlock_pair();
    wr(21'h555, 16'h0090);
    chk("R5 ID entry", 32'(mode), 32'd1);
    repeat (5) @(negedge clk);
    chk("R8 ID holds", 32'(mode), 32'd1);
    unlock_pair();
    wr(21'h555, 16'h00F0);
    chk("R8 ID exit", 32'(mode), 32'd0);
    unlock_pair();
    wr(21'h555, 16'h0098);
    chk("R6 CFI entry by preamble", 32'(mode), 32'd2);
    repeat (3) @(negedge clk);
    chk("R8 CFI holds", 32'(mode), 32'd2);
    unlock_pair();
    wr(21'h555, 16'h00F0);
    chk("R8 CFI exit", 32'(mode), 32'd0);
    wr(21'h055, 16'h0098);
    chk("R7 CFI shortcut", 32'(mode), 32'd2);
    unlock_pair();
    wr(21'h555, 16'h00F0);
    chk("R8 exit after shortcut", 32'(mode), 32'd0);
  endtask

  task automatic t_busy();
    unlock_pair();
    wr(21'h555, 16'h0090);
    busy = 1'b1;
    unlock_pair();
    wr(21'h555, 16'h00F0);
    chk("R9 exit ignored while busy", 32'(mode), 32'd1);
    wr(21'h00777, 16'h0001);
    chk("R9 stray write ignored while busy", 32'(mode), 32'd1);
    busy = 1'b0;
    unlock_pair();
    wr(21'h555, 16'h00F0);
    chk("R9 exit once idle", 32'(mode), 32'd0);
  endtask

  task automatic t_upper();
    wr(21'h1FF555, 16'hFFAA);
    wr(21'h0A2AA, 16'h1255);
    wr(21'h1F8D55, 16'h7EA0);
    wr(21'h00042, 16'h5A5A);
    chk("R10 program with upper bits set", 32'(mode), 32'd3);
    chk("R10 program data", 32'(op_data), 32'h5A5A);
    @(negedge clk);
    wr(21'h1C0055, 16'h3498);
    chk("R10 shortcut with upper bits set", 32'(mode), 32'd2);
    unlock_pair();
    wr(21'h555, 16'hABF0);
    chk("R10 exit with upper bits set", 32'(mode), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase(21'h00555, 8'h10, 2'd1);
    t_erase(21'h1F000, 8'h30, 2'd2);
    t_erase(21'h08000, 8'h50, 2'd3);
    t_abort();
    t_id_cfi();
    t_busy();
    t_upper();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule